// File: doc/BRIEF.md
# Target Write FIFO Read Port

This block sits between a bus target's write-data path and the application logic that consumes posted write data. The target side pushes 64-bit elements into a 32-entry store. Each element carries eight byte enables, a burst flag and a tag that marks the final element of its write transaction. The application side sees the oldest element at once, in first-word fall-through fashion. It removes that element by raising a read enable for one clock.

The block also frames each transaction for the application. A request line stays low while a transaction is being served, including stretches where the store has run dry in mid-burst. It rises for exactly one clock after the final element has been taken. A last-element flag marks that final element. Active-low empty and almost-empty flags follow the live occupancy, so they can toggle either way during a burst while pushes and reads overlap. An asynchronous active-low clear throws away all stored data and returns the framing state machine to idle.

Top module: `twr_rdport`

## Requirements
- R1: While `rst_n` or `clr_n` is low, and on the first cycle after both are released, `empty_n`=0, `aempty_n`=0, `req_n`=1, `rd_last_n`=1, `wr_full`=0 and `rd_err`=0.
- R2: Elements come out in the order they were written, and `rd_data` and `rd_be` are unchanged. When `empty_n`=1, the oldest element is shown without a read. An accepted read removes it at the next rising edge.
- R3: The store holds 32 elements. `wr_full` is 1 exactly when 32 are held. A write while `wr_full`=1 is dropped and leaves the contents unchanged.
- R4: `empty_n` is 1 exactly when at least one element is held. It changes on the same edge that accepts the write or read causing the change. A write and a read accepted together leave the occupancy unchanged.
- R5: `aempty_n` is 0 whenever four or fewer elements are held, and 1 when five or more are held.
- R6: `rd_last_n` is 0 exactly when an element is shown and that element was written with `wr_eot`=1. For a one-element transaction it is low for the whole time that element is shown. It is 1 when the store is empty.
- R7: `req_n` is 0 while a transaction is open: data is present, or some elements of the transaction have been read but its final element has not. The edge that accepts a final element drives `req_n` to 1 for exactly one clock. After that clock, `req_n` is 0 again if data is present.
- R8: A read is accepted only when `empty_n`=1 and `req_n`=0. Any other read is ignored: `rd_err` is 1 in that same cycle and nothing is removed.
- R9: `rd_burst` repeats, for each element, the `wr_burst` value it was written with.
- R10: Taking `clr_n` low empties the store at once, without waiting for a clock edge, and ends any open transaction. After release, the next element written is the first one shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| clr_n | input | 1 | Asynchronous application clear, active low |
| wr_en | input | 1 | Push one element |
| wr_data | input | 64 | Element data |
| wr_be | input | 8 | Element byte enables |
| wr_burst | input | 1 | Burst flag of the element |
| wr_eot | input | 1 | Element is the final one of its transaction |
| wr_full | output | 1 | Store holds 32 elements |
| rd_en | input | 1 | Application read enable |
| rd_data | output | 64 | Oldest element data |
| rd_be | output | 8 | Oldest element byte enables |
| rd_burst | output | 1 | Oldest element burst flag |
| rd_last_n | output | 1 | Oldest element ends its transaction, active low |
| rd_err | output | 1 | Read enable seen while reading is not allowed |
| empty_n | output | 1 | Store empty, active low |
| aempty_n | output | 1 | Four or fewer elements held, active low |
| req_n | output | 1 | Transaction open, active low |

## Verification
The overflow check assumes the target side respects `wr_full`, and the underflow check assumes nothing is removed unless data is present. The stimulus drives every write and read through one cycle task. That task predicts acceptance from a reference queue and a model of transaction state, and deliberately includes a write while full, reads while empty and a read during the one-clock request gap. The read-port checks still hold under those inputs, because the block itself gates such requests; the bench also confirms that each one is dropped.

// File: rtl/twr_pkg.sv
`timescale 1ns/1ps
package twr_pkg;

   typedef enum logic [1:0] {
      FR_IDLE = 2'd0,
      FR_BUSY = 2'd1,
      FR_GAP  = 2'd2
   } fr_state_e;

endpackage

// File: rtl/twr_store.sv
`timescale 1ns/1ps
module twr_store #(
   parameter int ENT_W = 74,
   parameter int DEPTH = 32,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             arst_n,
   input  logic             wr_en,
   input  logic             full,
   input  logic [ENT_W-1:0] wr_ent,
   input  logic             pop,
   output logic [ENT_W-1:0] head,
   output logic [CW-1:0]    count
);

   logic [ENT_W-1:0] mem [DEPTH];
   logic [AW-1:0]    wptr;
   logic [AW-1:0]    rptr;
   logic             push;

   assign push = wr_en && !full;

   function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
      return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   always_ff @(posedge clk) begin
      for (int i = 0; i < DEPTH; i++) begin
         if (push && (wptr == AW'(i))) begin
            mem[i] <= wr_ent;
         end
      end
   end

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         if (push) wptr <= ptr_next(wptr);
         if (pop)  rptr <= ptr_next(rptr);
         case ({push, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   assign head = mem[rptr];

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!arst_n)
      push |-> (count < CW'(DEPTH)));   // R3
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!arst_n)
      pop |-> (count != '0));           // R8

endmodule

// File: rtl/twr_flags.sv
`timescale 1ns/1ps
module twr_flags #(
   parameter int DEPTH    = 32,
   parameter int AE_LEVEL = 4,
   localparam int CW      = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          arst_n,
   input  logic [CW-1:0] count,
   output logic          empty_n,
   output logic          aempty_n,
   output logic          full
);

   assign empty_n  = (count != '0);
   assign aempty_n = (count > CW'(AE_LEVEL));
   assign full     = (count == CW'(DEPTH));

   AST_AEMPTY_COVERS_EMPTY: assert property (@(posedge clk) disable iff (!arst_n)
      !empty_n |-> !aempty_n);          // R5
   AST_FULL_NOT_EMPTY: assert property (@(posedge clk) disable iff (!arst_n)
      full |-> (empty_n && aempty_n));  // R3

endmodule

// File: rtl/twr_framer.sv
`timescale 1ns/1ps
module twr_framer
   import twr_pkg::*;
(
   input  logic clk,
   input  logic arst_n,
   input  logic rd_en,
   input  logic empty_n,
   input  logic head_eot,
   output logic pop,
   output logic rd_err,
   output logic req_n,
   output logic last_n
);

   fr_state_e state;
   fr_state_e state_nx;
   logic      open_txn;

   assign open_txn = (state == FR_BUSY) || ((state == FR_IDLE) && empty_n);
   assign req_n    = !open_txn;
   assign pop      = rd_en && empty_n && open_txn;
   assign rd_err   = rd_en && !pop;
   assign last_n   = !(empty_n && head_eot);

   always_comb begin
      state_nx = state;
      if (pop && head_eot) begin
         state_nx = FR_GAP;
      end else if (state == FR_GAP) begin
         state_nx = FR_IDLE;
      end else if (pop) begin
         state_nx = FR_BUSY;
      end
   end

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) state <= FR_IDLE;
      else         state <= state_nx;
   end

   AST_LAST_NEEDS_DATA: assert property (@(posedge clk) disable iff (!arst_n)
      !last_n |-> empty_n);             // R6
   AST_GAP_AFTER_LAST: assert property (@(posedge clk) disable iff (!arst_n)
      (pop && !last_n) |=> req_n);      // R7
   AST_GAP_ENDS: assert property (@(posedge clk) disable iff (!arst_n)
      (req_n && $past(pop && !last_n)) |=> (req_n == !empty_n)); // R7
   AST_NO_POP_IN_GAP: assert property (@(posedge clk) disable iff (!arst_n)
      req_n |-> !pop);                  // R8

endmodule

// File: rtl/twr_rdport.sv
`timescale 1ns/1ps
module twr_rdport #(
   parameter int DATA_W   = 64,
   parameter int DEPTH    = 32,
   parameter int AE_LEVEL = 4,
   localparam int BE_W    = DATA_W / 8,
   localparam int ENT_W   = DATA_W + BE_W + 2,
   localparam int CW      = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [BE_W-1:0]   wr_be,
   input  logic              wr_burst,
   input  logic              wr_eot,
   output logic              wr_full,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic [BE_W-1:0]   rd_be,
   output logic              rd_burst,
   output logic              rd_last_n,
   output logic              rd_err,
   output logic              empty_n,
   output logic              aempty_n,
   output logic              req_n
);

   if ((DATA_W % 8) != 0 || DATA_W < 8) begin : g_bad_width
      $error("twr_rdport: DATA_W must be a nonzero multiple of 8");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("twr_rdport: DEPTH must be at least 2");
   end
   if (AE_LEVEL < 1 || AE_LEVEL >= DEPTH) begin : g_bad_level
      $error("twr_rdport: AE_LEVEL must lie in 1..DEPTH-1");
   end

   logic             arst_n;
   logic [ENT_W-1:0] wr_ent;
   logic [ENT_W-1:0] head;
   logic [CW-1:0]    count;
   logic             pop;

   assign arst_n = rst_n & clr_n;
   assign wr_ent = {wr_eot, wr_burst, wr_be, wr_data};

   twr_store #(
      .ENT_W (ENT_W),
      .DEPTH (DEPTH)
   ) u_store (
      .clk    (clk),
      .arst_n (arst_n),
      .wr_en  (wr_en),
      .full   (wr_full),
      .wr_ent (wr_ent),
      .pop    (pop),
      .head   (head),
      .count  (count)
   );

   twr_flags #(
      .DEPTH    (DEPTH),
      .AE_LEVEL (AE_LEVEL)
   ) u_flags (
      .clk      (clk),
      .arst_n   (arst_n),
      .count    (count),
      .empty_n  (empty_n),
      .aempty_n (aempty_n),
      .full     (wr_full)
   );

   twr_framer u_framer (
      .clk      (clk),
      .arst_n   (arst_n),
      .rd_en    (rd_en),
      .empty_n  (empty_n),
      .head_eot (head[ENT_W-1]),
      .pop      (pop),
      .rd_err   (rd_err),
      .req_n    (req_n),
      .last_n   (rd_last_n)
   );

   assign rd_data  = head[DATA_W-1:0];
   assign rd_be    = head[DATA_W +: BE_W];
   assign rd_burst = head[ENT_W-2];

endmodule

// File: tb/twr_rdport_bench.sv
`timescale 1ns/1ps
module twr_rdport_bench;

   localparam int DEPTH = 32;

   typedef struct packed {
      logic        eot;
      logic        burst;
      logic [7:0]  be;
      logic [63:0] data;
   } ent_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        clr_n = 1'b1;
   logic        wr_en = 1'b0;
   logic [63:0] wr_data = '0;
   logic [7:0]  wr_be = '0;
   logic        wr_burst = 1'b0;
   logic        wr_eot = 1'b0;
   logic        wr_full;
   logic        rd_en = 1'b0;
   logic [63:0] rd_data;
   logic [7:0]  rd_be;
   logic        rd_burst;
   logic        rd_last_n;
   logic        rd_err;
   logic        empty_n;
   logic        aempty_n;
   logic        req_n;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   ent_t mq[$];
   bit   busy = 0;
   bit   gap = 0;

   always #2.5 clk = ~clk;

   twr_rdport u_twr_rdport (
      .clk(clk), .rst_n(rst_n), .clr_n(clr_n),
      .wr_en(wr_en), .wr_data(wr_data), .wr_be(wr_be), .wr_burst(wr_burst),
      .wr_eot(wr_eot), .wr_full(wr_full), .rd_en(rd_en), .rd_data(rd_data),
      .rd_be(rd_be), .rd_burst(rd_burst), .rd_last_n(rd_last_n),
      .rd_err(rd_err), .empty_n(empty_n), .aempty_n(aempty_n), .req_n(req_n)
   );

   task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", what, act, exp);
      end
   endtask

   function automatic bit exp_req_n();
      if (gap) return 1'b1;
      if (busy) return 1'b0;
      return !(mq.size() > 0);
   endfunction

   task automatic check_outs();
      chk("R4 empty_n", empty_n, mq.size() > 0);
      chk("R5 aempty_n", aempty_n, mq.size() > 4);
      chk("R3 wr_full", wr_full, mq.size() == DEPTH);
      chk("R7 req_n", req_n, exp_req_n());
      if (mq.size() > 0) begin
         chk("R2 rd_data", rd_data, mq[0].data);
         chk("R2 rd_be", rd_be, mq[0].be);
         chk("R9 rd_burst", rd_burst, mq[0].burst);
         chk("R6 rd_last_n", rd_last_n, !mq[0].eot);
      end else begin
         chk("R6 rd_last_n idle", rd_last_n, 1'b1);
      end
   endtask

   function automatic ent_t mk(input int n, input bit burst, input bit eot);
      ent_t e;
      e.data  = {32'hA5A5_0000 + 32'(n), 32'h1357_0000 ^ 32'(n * 7)};
      e.be    = 8'(8'hFF ^ n[7:0]);
      e.burst = burst;
      e.eot   = eot;
      return e;
   endfunction

   // One clock: drive, check rd_err, step, update model, check outputs.
   task automatic cyc(input bit w, input ent_t e, input bit r);
      bit acc;
      bit psh;
      ent_t p;
      wr_en = w; wr_data = e.data; wr_be = e.be; wr_burst = e.burst; wr_eot = e.eot;
      rd_en = r;
      #1;
      acc = r && (mq.size() > 0) && !exp_req_n();
      psh = w && (mq.size() < DEPTH);
      chk("R8 rd_err", rd_err, r && !acc);
      @(posedge clk); #1;
      wr_en = 1'b0; rd_en = 1'b0;
      gap = 1'b0;
      if (acc) begin
         p = mq.pop_front();
         if (p.eot) begin gap = 1'b1; busy = 1'b0; end
         else busy = 1'b1;
      end
      if (psh) mq.push_back(e);
      check_outs();
   endtask

   task automatic t_reset();
      chk("R1 empty_n", empty_n, 1'b0);
      chk("R1 aempty_n", aempty_n, 1'b0);
      chk("R1 req_n", req_n, 1'b1);
      chk("R1 rd_last_n", rd_last_n, 1'b1);
      chk("R1 wr_full", wr_full, 1'b0);
      @(posedge clk); #1;
      rst_n = 1'b1;
      @(posedge clk); #1;
      chk("R1 rd_err", rd_err, 1'b0);
      check_outs();
   endtask

   task automatic t_single();
      cyc(1, mk(1, 0, 1), 0);
      cyc(0, mk(0, 0, 0), 0);          // R6: last low for the whole phase
      cyc(0, mk(0, 0, 0), 1);          // R7: gap follows
      cyc(0, mk(0, 0, 0), 0);
   endtask

   task automatic t_back_to_back();
      for (int i = 0; i < 3; i++) cyc(1, mk(10 + i, 1, i == 2), 0);
      for (int i = 0; i < 2; i++) cyc(1, mk(20 + i, 1, i == 1), 0);
      cyc(0, mk(0, 0, 0), 1);
      cyc(0, mk(0, 0, 0), 1);
      cyc(0, mk(0, 0, 0), 1);          // final of first txn, gap next
      cyc(0, mk(0, 0, 0), 1);          // R8: read in gap ignored
      cyc(0, mk(0, 0, 0), 1);
      cyc(0, mk(0, 0, 0), 1);
      cyc(0, mk(0, 0, 0), 0);
   endtask

   task automatic t_drained_mid_burst();
      cyc(1, mk(30, 1, 0), 0);
      cyc(0, mk(0, 0, 0), 1);          // R7: empty but still open
      cyc(0, mk(0, 0, 0), 1);          // R8: read while empty
      cyc(1, mk(31, 1, 0), 1);         // R4: push and pop together ignored pop (empty)
      cyc(1, mk(32, 1, 1), 1);         // R4: simultaneous push and pop
      cyc(0, mk(0, 0, 0), 1);
      cyc(0, mk(0, 0, 0), 0);
   endtask

   task automatic t_fill();
      for (int i = 0; i < DEPTH; i++) cyc(1, mk(100 + i, 1, i == DEPTH - 1), 0);
      cyc(1, mk(999, 0, 1), 0);        // R3: dropped when full
      for (int i = 0; i < DEPTH; i++) cyc(0, mk(0, 0, 0), 1);
      cyc(0, mk(0, 0, 0), 0);
   endtask

   task automatic t_clear();
      for (int i = 0; i < 3; i++) cyc(1, mk(200 + i, 1, 0), 0);
      cyc(0, mk(0, 0, 0), 1);
      #1 clr_n = 1'b0;
      #0.5;
      chk("R10 empty_n async", empty_n, 1'b0);
      chk("R10 req_n async", req_n, 1'b1);
      mq.delete(); busy = 1'b0; gap = 1'b0;
      @(posedge clk); #1;
      clr_n = 1'b1;
      @(posedge clk); #1;
      check_outs();
      cyc(1, mk(300, 0, 1), 0);        // R10: fresh element shown first
      cyc(0, mk(0, 0, 0), 1);
      cyc(0, mk(0, 0, 0), 0);
   endtask

   initial begin
      #(5.0 * 100000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      #1;
      t_reset();
      t_single();
      t_back_to_back();
      t_drained_mid_burst();
      t_fill();
      t_clear();
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule